// File: doc/BRIEF.md
# Prefix-Sum Thread ID Dispatcher

This block hands out thread IDs to a set of worker units during a parallel section. The master starts a section with a one-cycle `spawn_i` pulse. With that pulse it supplies the highest thread ID to run, called the bound, and the base ID of the first thread. Each worker is given its first thread straight away. After that, a worker raises its request bit each time it completes a thread and receives the ID of the next one.

All requests raised in the same cycle are served together, with no extra cycles. A prefix count over the request vector ranks the requesting workers by port index. Each requester gets the shared high-water register plus one plus its rank. The register then advances by the number of requests. When a granted ID lies beyond the bound, the worker is told not to run it and is marked finished. Once every worker is finished, the section closes and `done_o` tells the master to resume serial execution.

All outputs are registered. Every grant appears in the cycle after the edge that accepted the spawn or request.

Top module: `ps_thread_dispatch`

## Requirements
- R1: While `rst` is high and after it is released, with no spawn, all grant outputs, `finished_o`, `active_o`, `done_o` and `bound_o` are zero.
- R2: A spawn accepted at a clock edge sets `active_o` and shows the bound on `bound_o` after that edge; the bound stays fixed until the next accepted spawn.
- R3: At an accepted spawn, worker i receives a grant with ID base+i after the same edge, for every i below N.
- R4: Requests sampled at one edge are granted after that edge, in that single cycle. A requesting worker k gets X+1+(number of requesting workers below index k), where X is the highest ID issued so far. So simultaneous grants are consecutive and ordered by port index.
- R5: Within a section no ID is issued twice with the run flag set. Every ID from base to the bound is issued exactly once with the run flag set.
- R6: A grant whose ID is at most the bound carries `grant_run_o`=1. A larger ID, with the comparison made without wrap at the top of the ID range, carries `grant_run_o`=0 and sets that worker's `finished_o` bit, which then stays set until the next accepted spawn.
- R7: A request from a finished worker, or any request while no section is active, produces no grant and changes no output.
- R8: One cycle after all `finished_o` bits are set, `active_o` falls and `done_o` rises. `done_o` holds until the next accepted spawn.
- R9: A spawn pulse while `active_o` is high is ignored: the bound, the grants and the finished flags are unaffected.
- R10: After done, the next spawn clears `done_o` and reloads all `finished_o` bits. With a bound below base+i, worker i starts out finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spawn_i | input | 1 | One-cycle pulse that opens a section |
| spawn_last_i | input | W | Highest thread ID of the section (bound) |
| spawn_base_i | input | W | First thread ID of the section |
| req_i | input | N | Per-worker request for the next ID |
| grant_valid_o | output | N | Per-worker grant strobe, one cycle |
| grant_run_o | output | N | Granted ID is within the bound, run it |
| grant_id_o | output | N*W | Per-worker granted ID, worker k in bits k*W +: W |
| finished_o | output | N | Per-worker finished flag |
| bound_o | output | W | Bound of the current section, seen by all workers |
| active_o | output | 1 | Section in progress |
| done_o | output | 1 | All workers finished, master may resume |

## Verification
The bench uses the default eight workers and 16-bit IDs. Eight workers allow up to eight simultaneous requests, so the prefix ranking is exercised across the whole request vector. A 16-bit ID lets a directed section place its base just below 65535, where grants beyond the bound wrap in the ID field but must still count as out of range. Random sections with bounds of a few hundred cover many rounds of mixed request patterns. Short sections with a bound below base+N-1 reach the case where workers start out finished.

// File: rtl/ps_disp_pkg.sv
package ps_disp_pkg;

  // width able to hold a count from 0 to n inclusive
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // unsigned compare of an extended ID against a W-bit bound, no wrap
  function automatic logic within_bound(input logic [63:0] id, input logic [63:0] bound);
    return id <= bound;
  endfunction

endpackage

// File: rtl/ps_prefix_count.sv
module ps_prefix_count #(
  parameter int N  = 8,
  parameter int CW = 4
) (
  input  logic [N-1:0]    req,
  output logic [N*CW-1:0] offs,
  output logic [CW-1:0]   total
);

  logic [CW-1:0] run_sum [0:N];

  assign run_sum[0] = '0;

  generate
    for (genvar k = 0; k < N; k++) begin : g_rank
      assign run_sum[k+1]       = run_sum[k] + CW'(req[k]);
      assign offs[k*CW +: CW]   = run_sum[k];
    end
  endgenerate

  assign total = run_sum[N];

endmodule

// File: rtl/ps_section_ctrl.sv
module ps_section_ctrl #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spawn,
  input  logic [W-1:0]  bound_in,
  input  logic [W-1:0]  base_in,
  input  logic          all_fin,
  input  logic [CW-1:0] req_total,
  output logic          accept,
  output logic [W:0]    x_q,
  output logic [W-1:0]  y_q,
  output logic          active,
  output logic          done
);

  localparam logic [W:0] LAST_SLOT = (W+1)'(N - 1);

  assign accept = spawn & ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q    <= '0;
      y_q    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else if (accept) begin
      x_q    <= {1'b0, base_in} + LAST_SLOT;
      y_q    <= bound_in;
      active <= 1'b1;
      done   <= 1'b0;
    end else if (active) begin
      x_q <= x_q + (W+1)'(req_total);
      if (all_fin) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assert_spawn_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (active && spawn) |=> (y_q == $past(y_q)));

  assert_active_done_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(active && done));

  assert_x_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !spawn && !all_fin) |=> (x_q >= $past(x_q)));

endmodule

// File: rtl/ps_worker_slot.sv
module ps_worker_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W:0]   load_id,
  input  logic [W-1:0] load_bound,
  input  logic         serve,
  input  logic [W:0]   serve_id,
  input  logic [W-1:0] run_bound,
  output logic         gvalid,
  output logic         grun,
  output logic [W-1:0] gid,
  output logic         fin
);

  import ps_disp_pkg::*;

  logic load_ok, serve_ok;

  assign load_ok  = within_bound(64'(load_id), 64'(load_bound));
  assign serve_ok = within_bound(64'(serve_id), 64'(run_bound));

  always_ff @(posedge clk) begin
    if (rst) begin
      gvalid <= 1'b0;
      grun   <= 1'b0;
      gid    <= '0;
      fin    <= 1'b0;
    end else begin
      gvalid <= 1'b0;
      grun   <= 1'b0;
      if (load) begin
        gvalid <= 1'b1;
        grun   <= load_ok;
        gid    <= load_id[W-1:0];
        fin    <= ~load_ok;
      end else if (serve) begin
        gvalid <= 1'b1;
        grun   <= serve_ok;
        gid    <= serve_id[W-1:0];
        fin    <= ~serve_ok;
      end
    end
  end

  assert_fin_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (fin && !load) |=> fin);

  assert_run_not_fin_R6: assert property (@(posedge clk) disable iff (rst)
    grun |-> (gvalid && !fin));

endmodule

// File: rtl/ps_thread_dispatch.sv
module ps_thread_dispatch #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           spawn_i,
  input  logic [W-1:0]   spawn_last_i,
  input  logic [W-1:0]   spawn_base_i,
  input  logic [N-1:0]   req_i,
  output logic [N-1:0]   grant_valid_o,
  output logic [N-1:0]   grant_run_o,
  output logic [N*W-1:0] grant_id_o,
  output logic [N-1:0]   finished_o,
  output logic [W-1:0]   bound_o,
  output logic           active_o,
  output logic           done_o
);

  import ps_disp_pkg::*;

  localparam int CW = count_width(N);

  logic          accept;
  logic [W:0]    x_q;
  logic [W-1:0]  y_q;
  logic [N-1:0]  req_eff;
  logic [N*CW-1:0] offs;
  logic [CW-1:0] req_total;

  // only live, unfinished workers may draw an ID
  assign req_eff = req_i & ~finished_o & {N{active_o}};

  ps_prefix_count #(.N(N), .CW(CW)) u_rank (
    .req   (req_eff),
    .offs  (offs),
    .total (req_total)
  );

  ps_section_ctrl #(.N(N), .W(W), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .spawn     (spawn_i),
    .bound_in  (spawn_last_i),
    .base_in   (spawn_base_i),
    .all_fin   (&finished_o),
    .req_total (req_total),
    .accept    (accept),
    .x_q       (x_q),
    .y_q       (y_q),
    .active    (active_o),
    .done      (done_o)
  );

  assign bound_o = y_q;

  generate
    for (genvar k = 0; k < N; k++) begin : g_slot
      logic [W:0] init_id;
      logic [W:0] next_id;

      assign init_id = {1'b0, spawn_base_i} + (W+1)'(k);
      assign next_id = x_q + (W+1)'(1) + (W+1)'(offs[k*CW +: CW]);

      ps_worker_slot #(.W(W)) u_slot (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .load_id    (init_id),
        .load_bound (spawn_last_i),
        .serve      (req_eff[k]),
        .serve_id   (next_id),
        .run_bound  (y_q),
        .gvalid     (grant_valid_o[k]),
        .grun       (grant_run_o[k]),
        .gid        (grant_id_o[k*W +: W]),
        .fin        (finished_o[k])
      );

      assert_grant_cause_R4: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o[k] |-> $past(req_i[k] || spawn_i));

      assert_run_in_bound_R6: assert property (@(posedge clk) disable iff (rst)
        grant_run_o[k] |-> (grant_id_o[k*W +: W] <= bound_o));
    end
  endgenerate

  assert_done_all_fin_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (&finished_o));

  assert_idle_no_grant_R7: assert property (@(posedge clk) disable iff (rst)
    (!active_o && !spawn_i) |=> (grant_valid_o == '0));

endmodule

// File: tb/ps_thread_dispatch_test.sv
module ps_thread_dispatch_test;

  localparam int N = 8;
  localparam int W = 16;
  localparam longint MASK = (64'd1 << W) - 1;

  logic           clk = 1'b0;
  logic           rst;
  logic           spawn_i;
  logic [W-1:0]   spawn_last_i;
  logic [W-1:0]   spawn_base_i;
  logic [N-1:0]   req_i;
  logic [N-1:0]   grant_valid_o;
  logic [N-1:0]   grant_run_o;
  logic [N*W-1:0] grant_id_o;
  logic [N-1:0]   finished_o;
  logic [W-1:0]   bound_o;
  logic           active_o;
  logic           done_o;

  ps_thread_dispatch #(.N(N), .W(W)) uut (.*);

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // requirement model state
  longint m_x, m_y, m_base;
  logic   m_active, m_done;
  logic [N-1:0] m_fin;
  logic [N-1:0] busy;
  bit     mark [0:1023];
  int     n_issued;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic sp, input longint yb, input longint bs, input logic [N-1:0] rq);
    logic [N-1:0] e_gv, e_run;
    longint e_id [N];
    logic accept, allfin_old;
    int cnt;
    spawn_i = sp; spawn_last_i = W'(yb); spawn_base_i = W'(bs); req_i = rq;
    e_gv = '0; e_run = '0;
    for (int k = 0; k < N; k++) e_id[k] = 0;
    accept = sp && !m_active;
    if (accept) begin
      for (int k = 0; k < N; k++) begin
        e_id[k] = bs + k; e_gv[k] = 1'b1;
        e_run[k] = (e_id[k] <= yb); m_fin[k] = !e_run[k];
      end
      m_x = bs + N - 1; m_y = yb; m_base = bs; m_active = 1'b1; m_done = 1'b0;
      for (int i = 0; i < 1024; i++) mark[i] = 1'b0;
      n_issued = 0;
    end else if (m_active) begin
      allfin_old = &m_fin;
      cnt = 0;
      for (int k = 0; k < N; k++) begin
        if (rq[k] && !m_fin[k]) begin
          e_id[k] = m_x + 1 + cnt; cnt++; e_gv[k] = 1'b1;
          e_run[k] = (e_id[k] <= m_y); m_fin[k] = !e_run[k];
        end
      end
      m_x = m_x + cnt;
      if (allfin_old) begin m_active = 1'b0; m_done = 1'b1; end
    end
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      chk(grant_valid_o[k] == e_gv[k], accept ? "R3 grant valid" : "R4 grant valid",
          grant_valid_o[k], e_gv[k]);
      chk(grant_run_o[k] == e_run[k], "R6 run flag", grant_run_o[k], e_run[k]);
      if (e_gv[k])
        chk(longint'(grant_id_o[k*W +: W]) == (e_id[k] & MASK), accept ? "R3 initial id" : "R4 next id",
            grant_id_o[k*W +: W], e_id[k] & MASK);
      if (grant_valid_o[k] && grant_run_o[k]) begin
        longint off;
        off = longint'(grant_id_o[k*W +: W]) - m_base;
        busy[k] = 1'b1;
        if (off >= 0 && off < 1024) begin
          chk(!mark[off], "R5 duplicate id", grant_id_o[k*W +: W], -1);
          mark[off] = 1'b1;
        end
        n_issued++;
      end
    end
    chk(finished_o == m_fin, "R6 finished flags", finished_o, m_fin);
    chk(active_o == m_active, "R2 active", active_o, m_active);
    chk(done_o == m_done, "R8 done", done_o, m_done);
    chk(longint'(bound_o) == (m_y & MASK), "R2 bound", bound_o, m_y & MASK);
  endtask

  task automatic finish_check;
    longint span;
    int miss;
    span = (m_y >= m_base) ? (m_y - m_base + 1) : 0;
    miss = 0;
    for (longint o = 0; o < span; o++) if (!mark[o]) miss++;
    chk(miss == 0, "R5 ids missing", miss, 0);
    chk(longint'(n_issued) == span, "R5 ids issued", n_issued, span);
  endtask

  // mode 0: every busy worker requests each cycle; mode 1: random subset
  task automatic run_section(input longint yb, input longint bs, input int mode);
    logic [N-1:0] rq;
    busy = '0;
    step(1'b1, yb, bs, '0);
    for (int c = 0; c < 4000 && !m_done; c++) begin
      rq = '0;
      for (int k = 0; k < N; k++)
        if (busy[k] && (mode == 0 || ($urandom % 3) != 0)) begin
          rq[k] = 1'b1; busy[k] = 1'b0;
        end
      step(1'b0, 0, 0, rq);
    end
    chk(m_done && done_o, "R8 section closed", done_o, 1);
    finish_check();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    rst = 1'b1; spawn_i = 1'b0; spawn_last_i = '0; spawn_base_i = '0; req_i = '0;
    m_x = 0; m_y = 0; m_base = 0; m_active = 0; m_done = 0; m_fin = '0; busy = '0; n_issued = 0;
    repeat (3) @(negedge clk);
    chk(grant_valid_o == '0 && finished_o == '0 && !active_o && !done_o && bound_o == '0,
        "R1 reset state", {active_o, done_o}, 0);
    rst = 1'b0;
    step(1'b0, 0, 0, '1);
    chk(grant_valid_o == '0 && !active_o, "R1 idle after reset", grant_valid_o, 0);

    // all workers request together each round
    run_section(20, 0, 0);

    // requests after done are ignored
    step(1'b0, 0, 0, '1);
    chk(grant_valid_o == '0 && done_o, "R7 request while idle", grant_valid_o, 0);

    // short section: upper workers start finished
    busy = '0;
    step(1'b1, 3, 0, '0);
    chk(done_o == 1'b0 && finished_o == 8'hF0, "R10 reload after done", finished_o, 8'hF0);
    step(1'b1, 99, 50, '0);
    chk(bound_o == 3 && grant_valid_o == '0, "R9 spawn while active", bound_o, 3);
    step(1'b0, 0, 0, 8'hF0);
    chk(grant_valid_o == '0, "R7 finished worker request", grant_valid_o, 0);
    for (int c = 0; c < 20 && !m_done; c++) step(1'b0, 0, 0, 8'h0F);
    finish_check();

    // bound below base: all workers finished at once
    run_section(5, 9, 0);
    chk(finished_o == '1, "R10 all start finished", finished_o, 8'hFF);

    // top of ID range: no wrap in the bound comparison
    run_section(65535, 65530, 0);

    // random request patterns
    for (int s = 0; s < 8; s++)
      run_section(longint'($urandom % 400), longint'($urandom % 100), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule